// File: doc/BRIEF.md
# Sprite Pixel Serializer and Priority Merger

This block turns up to eight preloaded sprite rows into a stream of object pixels and merges that stream with the background (playfield) pixel of the same screen position. Each slot is loaded during the blanking part of a line with two pattern bit-planes, a two-bit palette number, a behind-background flag and a horizontal start position. Once drawing begins, the slot counts visible pixels down to its start position and then emits its eight pixels, most significant pattern bit first.

On each visible pixel clock the lowest-numbered slot with an opaque pixel wins the object arbitration. The winner is then compared with the playfield pixel to form a 5-bit palette index. Because the object arbitration comes first, a behind-background object in a low slot can mask a foreground object in a higher slot. A sticky hit flag reports when the object held in slot 0 and marked as the primary object overlaps an opaque playfield pixel. The flag stays set until a frame-start strobe clears it.

Top module: `sprite_pixel_mux`

## Requirements
- R1: After reset the palette index and the hit flag are 0, and every slot is transparent, so an opaque playfield pixel passes through unchanged.
- R2: A slot loaded with start position X outputs transparent pixels for the first X enabled pixel clocks after the load. It shows its eight pattern pixels on enabled clocks X to X+7 and is transparent again after that.
- R3: A slot pixel value is {high-plane bit, low-plane bit}, taken from bit 7 of both planes first and then moving toward bit 0.
- R4: When the flip input is 1 at load, both pattern bytes are stored bit-reversed, so bit 0 is shown first.
- R5: The object pixel comes from the lowest-numbered slot whose pixel is non-zero. If every slot is transparent, the object pixel is transparent.
- R6: The object pixel is used when it is non-zero and either its behind flag is 0 or the playfield pixel value (pf_pix[1:0]) is 0. Otherwise the playfield pixel is used.
- R7: An object index is {1, palette[1:0], pixel[1:0]} and a playfield index is {0, pf_pix[3:0]}. An object index therefore never has bits 1..0 equal to 0.
- R8: When neither the object pixel nor the playfield pixel is opaque, the index is 0, whatever the palette bits of pf_pix are.
- R9: The hit flag is set by an enabled pixel in which slot 0 wins with an opaque pixel, slot 0 was loaded with the primary marker, and the playfield pixel is opaque. The behind flag does not matter. A win by any other slot never sets it.
- R10: The hit flag stays set until frame_clr is asserted. frame_clr clears it on the next clock and takes precedence over a hit in that same cycle.
- R11: pal_idx is registered and updates one clock after an enabled pixel. While pix_en is 0, pal_idx holds its value and no slot counter or shifter advances.
- R12: A behind-background object in a lower slot that wins the object arbitration hides a foreground object in a higher slot wherever the playfield pixel is opaque. The playfield is shown there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the slot addressed by load_sel |
| load_sel | input | 3 | Slot number to load |
| load_pat_lo | input | 8 | Low pattern plane |
| load_pat_hi | input | 8 | High pattern plane |
| load_pal | input | 2 | Object palette number |
| load_behind | input | 1 | 1: object sits behind opaque playfield |
| load_x | input | 8 | Horizontal start position |
| load_flip | input | 1 | Reverse pattern bit order at load |
| load_primary | input | 1 | Slot 0 holds the primary object (ignored for other slots) |
| pix_en | input | 1 | Visible pixel clock enable |
| pf_pix | input | 4 | Playfield pixel {palette[1:0], value[1:0]} |
| frame_clr | input | 1 | Frame-start strobe clearing the hit flag |
| pal_idx | output | 5 | Registered palette index |
| obj0_hit | output | 1 | Sticky primary-object overlap flag |

## Verification
The hardest situation to reach is a primary object that overlaps the playfield while it loses the object arbitration. Slot 0 has to be transparent on exactly those pixels where slot 1 is opaque, so the hit flag must stay clear until slot 0's own opaque pixels arrive. A directed case loads slot 0 with a half-transparent pattern over a fully opaque slot 1. Randomized lines then load all eight slots with overlapping start positions, partly empty patterns, random flip and behind flags, and pauses in pix_en. A bench model of each slot predicts every index and the flag.

// File: rtl/sprmux_pkg.sv
`timescale 1ns/1ps
package sprmux_pkg;
  // Per-slot attributes latched at load time.
  typedef struct packed {
    logic [1:0] pal;     // object palette number
    logic       behind;  // 1: drawn behind opaque playfield
  } obj_attr_t;

  localparam int PIX_W = 2;  // pixel value width (two bit-planes)
  localparam int IDX_W = 5;  // palette index width
endpackage

// File: rtl/sprmux_slot.sv
`timescale 1ns/1ps
module sprmux_slot
  import sprmux_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int X_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [PAT_W-1:0] ld_lo,
  input  logic [PAT_W-1:0] ld_hi,
  input  obj_attr_t        ld_attr,
  input  logic [X_W-1:0]   ld_x,
  input  logic             ld_flip,
  input  logic             step,
  output logic [PIX_W-1:0] pix_o,
  output obj_attr_t        attr_o
);
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] lo_q, hi_q;
  logic [X_W-1:0]   x_q;
  logic [CNT_W-1:0] rem_q;
  obj_attr_t        attr_q;

  function automatic logic [PAT_W-1:0] mirror(input logic [PAT_W-1:0] v);
    logic [PAT_W-1:0] r;
    for (int b = 0; b < PAT_W; b++) r[b] = v[PAT_W-1-b];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      x_q    <= '0;
      rem_q  <= '0;
      attr_q <= '0;
    end else if (ld) begin
      lo_q   <= ld_flip ? mirror(ld_lo) : ld_lo;
      hi_q   <= ld_flip ? mirror(ld_hi) : ld_hi;
      x_q    <= ld_x;
      rem_q  <= CNT_W'(PAT_W);
      attr_q <= ld_attr;
    end else if (step) begin
      if (x_q != '0) begin
        x_q <= x_q - 1'b1;
      end else if (rem_q != '0) begin
        lo_q  <= lo_q << 1;
        hi_q  <= hi_q << 1;
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign pix_o  = (x_q == '0 && rem_q != '0) ? {hi_q[PAT_W-1], lo_q[PAT_W-1]} : '0;
  assign attr_o = attr_q;
endmodule

// File: rtl/sprmux_arb.sv
`timescale 1ns/1ps
module sprmux_arb
  import sprmux_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS-1:0][PIX_W-1:0] pix_i,
  input  obj_attr_t [NUM_SLOTS-1:0]       attr_i,
  output logic [PIX_W-1:0]                win_pix,
  output obj_attr_t                       win_attr,
  output logic                            win_first
);
  localparam int SEL_W = $clog2(NUM_SLOTS);

  logic [SEL_W-1:0] win;
  logic             found;

  always_comb begin
    win   = SEL_W'(NUM_SLOTS - 1);
    found = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && pix_i[i] != '0) begin
        win   = SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  assign win_pix   = pix_i[win];
  assign win_attr  = attr_i[win];
  assign win_first = (win == '0);
endmodule

// File: rtl/sprmux_merge.sv
`timescale 1ns/1ps
module sprmux_merge
  import sprmux_pkg::*;
(
  input  logic [PIX_W-1:0] obj_pix,
  input  obj_attr_t        obj_attr,
  input  logic             obj_first,
  input  logic             obj_prim,
  input  logic [3:0]       pf_pix,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);
  logic obj_op, pf_op, use_obj;

  assign obj_op  = (obj_pix != '0);
  assign pf_op   = (pf_pix[1:0] != 2'b00);
  assign use_obj = obj_op && (!obj_attr.behind || !pf_op);

  always_comb begin
    if (use_obj)    idx = {1'b1, obj_attr.pal, obj_pix};
    else if (pf_op) idx = {1'b0, pf_pix};
    else            idx = '0;
  end

  assign hit = obj_op && pf_op && obj_first && obj_prim;
endmodule

// File: rtl/sprite_pixel_mux.sv
`timescale 1ns/1ps
module sprite_pixel_mux
  import sprmux_pkg::*;
#(
  parameter  int NUM_SLOTS = 8,
  parameter  int PAT_W     = 8,
  parameter  int X_W       = 8,
  localparam int SEL_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [SEL_W-1:0] load_sel,
  input  logic [PAT_W-1:0] load_pat_lo,
  input  logic [PAT_W-1:0] load_pat_hi,
  input  logic [1:0]       load_pal,
  input  logic             load_behind,
  input  logic [X_W-1:0]   load_x,
  input  logic             load_flip,
  input  logic             load_primary,
  input  logic             pix_en,
  input  logic [3:0]       pf_pix,
  input  logic             frame_clr,
  output logic [4:0]       pal_idx,
  output logic             obj0_hit
);
  logic [NUM_SLOTS-1:0][PIX_W-1:0] slot_pix;
  obj_attr_t [NUM_SLOTS-1:0]       slot_attr;
  obj_attr_t                       ld_attr;
  logic [PIX_W-1:0]                win_pix;
  obj_attr_t                       win_attr;
  logic                            win_first;
  logic                            prim_q;
  logic [IDX_W-1:0]                idx_c;
  logic                            hit_c;

  assign ld_attr = '{pal: load_pal, behind: load_behind};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    sprmux_slot #(.PAT_W(PAT_W), .X_W(X_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .ld     (load_en && load_sel == SEL_W'(g)),
      .ld_lo  (load_pat_lo),
      .ld_hi  (load_pat_hi),
      .ld_attr(ld_attr),
      .ld_x   (load_x),
      .ld_flip(load_flip),
      .step   (pix_en),
      .pix_o  (slot_pix[g]),
      .attr_o (slot_attr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prim_q <= 1'b0;
    else if (load_en && load_sel == '0) prim_q <= load_primary;
  end

  sprmux_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .pix_i    (slot_pix),
    .attr_i   (slot_attr),
    .win_pix  (win_pix),
    .win_attr (win_attr),
    .win_first(win_first)
  );

  sprmux_merge u_merge (
    .obj_pix  (win_pix),
    .obj_attr (win_attr),
    .obj_first(win_first),
    .obj_prim (prim_q),
    .pf_pix   (pf_pix),
    .idx      (idx_c),
    .hit      (hit_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pal_idx  <= '0;
      obj0_hit <= 1'b0;
    end else begin
      if (pix_en) pal_idx <= idx_c;
      if (frame_clr)           obj0_hit <= 1'b0;
      else if (pix_en && hit_c) obj0_hit <= 1'b1;
    end
  end
endmodule

// File: rtl/sprmux_chk.sv
`timescale 1ns/1ps
module sprmux_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_en,
  input logic       frame_clr,
  input logic [4:0] pal_idx,
  input logic       obj0_hit
);
  AST_OBJ_OPAQUE: assert property (@(posedge clk) disable iff (rst)
    pal_idx[4] |-> pal_idx[1:0] != 2'b00);  // R7
  AST_BACKDROP_ZERO: assert property (@(posedge clk) disable iff (rst)
    pal_idx[1:0] == 2'b00 |-> pal_idx == 5'd0);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(pal_idx));  // R11
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    obj0_hit && !frame_clr |=> obj0_hit);  // R10
  AST_HIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    frame_clr |=> !obj0_hit);  // R10
  AST_HIT_ON_PIXEL: assert property (@(posedge clk) disable iff (rst)
    $rose(obj0_hit) |-> $past(pix_en));  // R9
endmodule

bind sprite_pixel_mux sprmux_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pix_en   (pix_en),
  .frame_clr(frame_clr),
  .pal_idx  (pal_idx),
  .obj0_hit (obj0_hit)
);

// File: tb/tb_sprite_pixel_mux.sv
`timescale 1ns/1ps
module tb_sprite_pixel_mux;
  logic       clk = 0;
  logic       rst = 1;
  logic       load_en = 0;
  logic [2:0] load_sel = 0;
  logic [7:0] load_pat_lo = 0, load_pat_hi = 0, load_x = 0;
  logic [1:0] load_pal = 0;
  logic       load_behind = 0, load_flip = 0, load_primary = 0;
  logic       pix_en = 0, frame_clr = 0;
  logic [3:0] pf_pix = 0;
  logic [4:0] pal_idx;
  logic       obj0_hit;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model of the eight slots.
  logic [7:0] m_lo[8], m_hi[8], m_x[8];
  int         m_rem[8];
  logic [1:0] m_pal[8];
  logic       m_beh[8];
  logic       m_prim = 0, m_hit = 0;
  logic [4:0] m_idx = 0;

  always #10 clk = ~clk;

  sprite_pixel_mux dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = v[7-b];
    return r;
  endfunction

  function automatic logic [1:0] mpix(int i);
    if (m_x[i] == 0 && m_rem[i] != 0) return {m_hi[i][7], m_lo[i][7]};
    return 2'b00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_x[i] = 0; m_rem[i] = 0; m_pal[i] = 0; m_beh[i] = 0;
    end
    m_prim = 0; m_hit = 0; m_idx = 0;
  endtask

  task automatic load(int s, logic [7:0] lo, logic [7:0] hi, logic [1:0] pal,
                      logic beh, logic [7:0] x, logic flip, logic prim);
    load_en = 1; load_sel = 3'(s); load_pat_lo = lo; load_pat_hi = hi;
    load_pal = pal; load_behind = beh; load_x = x; load_flip = flip; load_primary = prim;
    @(posedge clk); @(negedge clk);
    load_en = 0;
    m_lo[s] = flip ? rev8(lo) : lo;
    m_hi[s] = flip ? rev8(hi) : hi;
    m_x[s] = x; m_rem[s] = 8; m_pal[s] = pal; m_beh[s] = beh;
    if (s == 0) m_prim = prim;
  endtask

  task automatic empty_all();
    for (int s = 0; s < 8; s++) load(s, 8'h00, 8'h00, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0);
  endtask

  // One pixel clock: predict, drive, clock, compare.
  task automatic pixel(logic en, logic [3:0] pf, logic clr, string req);
    int w; logic [1:0] op; logic pfo, use_o, h;
    pix_en = en; pf_pix = pf; frame_clr = clr;
    w = 7;
    for (int i = 7; i >= 0; i--) if (mpix(i) != 0) w = i;
    op = mpix(w);
    pfo = (pf[1:0] != 0);
    use_o = (op != 0) && (!m_beh[w] || !pfo);
    h = (op != 0) && pfo && (w == 0) && m_prim;
    if (en) begin
      if (use_o)    m_idx = {1'b1, m_pal[w], op};
      else if (pfo) m_idx = {1'b0, pf};
      else          m_idx = 5'd0;
      for (int i = 0; i < 8; i++) begin
        if (m_x[i] != 0) m_x[i]--;
        else if (m_rem[i] != 0) begin
          m_lo[i] = m_lo[i] << 1; m_hi[i] = m_hi[i] << 1; m_rem[i]--;
        end
      end
    end
    if (clr) m_hit = 0;
    else if (en && h) m_hit = 1;
    @(posedge clk); @(negedge clk);
    pix_en = 0; frame_clr = 0;
    check({req, " index"}, 32'(pal_idx), 32'(m_idx));
    check({req, " hit"}, 32'(obj0_hit), 32'(m_hit));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state and transparent slots
    check("R1 reset index", 32'(pal_idx), 0);
    check("R1 reset hit", 32'(obj0_hit), 0);
    pixel(1, 4'b0110, 0, "R1");
    check("R1 playfield passthrough", 32'(pal_idx), 32'h06);

    // R2 R3: delayed start, MSB-first plane order
    load(3, 8'b1011_0001, 8'b0110_0011, 2'd2, 1'b0, 8'd5, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) begin
      pixel(1, 4'b0000, 0, "R2 R3");
      if (k == 5) check("R2 first pixel", 32'(pal_idx), 32'h19);
      if (k == 4) check("R2 before start", 32'(pal_idx), 32'h00);
      if (k == 13) check("R2 after end", 32'(pal_idx), 32'h00);
    end

    // R4: flip at load
    load(2, 8'b0000_0001, 8'b0000_0000, 2'd1, 1'b0, 8'd0, 1'b1, 1'b0);
    pixel(1, 4'b0000, 0, "R4");
    check("R4 flipped first pixel", 32'(pal_idx), 32'h15);
    for (int k = 0; k < 8; k++) pixel(1, 4'b0000, 0, "R4");

    // R11: pauses hold index and freeze shifting
    load(4, 8'b1010_1010, 8'b1100_1100, 2'd3, 1'b0, 8'd1, 1'b0, 1'b0);
    pixel(1, 4'b0000, 0, "R11");
    pixel(1, 4'b0000, 0, "R11");
    for (int k = 0; k < 3; k++) pixel(0, 4'b0001, 0, "R11 hold");
    for (int k = 0; k < 9; k++) pixel(1, 4'b0000, 0, "R11");

    // R8: transparent object and playfield give backdrop
    pixel(1, 4'b1100, 0, "R8");
    check("R8 backdrop", 32'(pal_idx), 0);

    // R12 R5 R6: behind object in slot 0 hides foreground slot 1
    empty_all();
    load(0, 8'hFF, 8'h00, 2'd1, 1'b1, 8'd0, 1'b0, 1'b0);
    load(1, 8'hFF, 8'hFF, 2'd3, 1'b0, 8'd0, 1'b0, 1'b0);
    pixel(1, 4'b0101, 0, "R12");
    check("R12 playfield shown", 32'(pal_idx), 32'h05);
    pixel(1, 4'b0100, 0, "R6");
    check("R6 behind object over clear playfield", 32'(pal_idx), 32'h15);
    for (int k = 0; k < 7; k++) pixel(1, 4'b0011, 0, "R5 R6");

    // R9: primary slot 0 loses arbitration, then wins
    empty_all();
    pixel(1, 4'b0000, 1, "R10");
    load(0, 8'h0F, 8'h00, 2'd0, 1'b0, 8'd0, 1'b0, 1'b1);
    load(1, 8'hFF, 8'h00, 2'd2, 1'b0, 8'd0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      pixel(1, 4'b0010, 0, "R9 slot1 wins");
      check("R9 no hit", 32'(obj0_hit), 0);
    end
    pixel(1, 4'b0010, 0, "R9 slot0 wins");
    check("R9 hit set", 32'(obj0_hit), 1);
    // R10: sticky, then clear beats a simultaneous hit
    pixel(1, 4'b0010, 0, "R10 sticky");
    pixel(1, 4'b0010, 1, "R10 clear wins");
    check("R10 cleared", 32'(obj0_hit), 0);
    for (int k = 0; k < 4; k++) pixel(1, 4'b0000, 0, "R10");

    // Random lines covering R2..R12
    for (int line = 0; line < 24; line++) begin
      for (int s = 0; s < 8; s++) begin
        logic empty;
        empty = ($urandom_range(0, 3) == 0);
        load(s, empty ? 8'h00 : 8'($urandom), empty ? 8'h00 : 8'($urandom),
             2'($urandom), 1'($urandom), 8'($urandom_range(0, 255)), 1'($urandom),
             1'($urandom));
      end
      pixel(1, 4'($urandom), 1, "R10 random");
      for (int p = 0; p < 270; p++)
        pixel(($urandom_range(0, 9) != 0), 4'($urandom),
              ($urandom_range(0, 99) == 0), "R5 R6 R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule